// File: doc/BRIEF.md
# Byte Lane Mask, Extract and Insert Unit

This unit does the byte work of a 64-bit integer datapath. It is built for unaligned load and store sequences. A sequence of that kind fetches two aligned quadwords, pulls out the wanted bytes with an extract, places new bytes with an insert, clears the old bytes with a mask, and merges the results. Every byte operation reads its byte offset from the low three bits of operand B. Each comes in a low form and a high form. The low form works on the part of a field that lies at or above the offset. The high form works on the part that spills past bit 63.

The unit also has two lane-zeroing operations and the three plain shifts. The zeroing operations use an 8-bit lane mask taken from B. The shifts use a shift amount taken from B[5:0]. A 7-bit function code picks the operation. Each request is qualified by an input valid. The result and an output valid are registered, so they appear one clock after the request.

Top module: `byte_lane_unit`

## Requirements
- R1: A request presented with `in_valid` high gives `out_valid` high and the new `result` on the next clock edge. Without a request, `out_valid` is low and `result` holds its last value. A synchronous reset drives `out_valid` and `result` to zero.
- R2: For the mask, extract and insert operations, the byte offset `off` is `opb[2:0]`, and `opb[63:3]` has no effect on the result.
- R3: Codes 0x02, 0x12, 0x22 and 0x32 return `opa` with a field of 1, 2, 4 or 8 bytes cleared. The field starts at byte `off` and runs upward. Field bytes that would fall above bit 63 are dropped.
- R4: Codes 0x52, 0x62 and 0x72 return `opa` with a field cleared. The field is the part of a 2, 4 or 8 byte field, placed at byte `off`, that lies above bit 63, moved down to start at byte 0. With `off` = 0 they return `opa` unchanged.
- R5: Codes 0x06, 0x16, 0x26 and 0x36 return `opa` shifted right by 8·`off` bits, keeping the low 1, 2, 4 or 8 bytes and zero-extending.
- R6: Codes 0x5a, 0x6a and 0x7a return `opa` shifted left by (64 − 8·`off`) mod 64 bits, keeping the low 2, 4 or 8 bytes.
- R7: Codes 0x0b, 0x1b, 0x2b and 0x3b return the low 1, 2, 4 or 8 bytes of `opa` shifted left by 8·`off` bits. Bits above bit 63 are dropped.
- R8: Codes 0x57, 0x67 and 0x77 return the bits of the low 2, 4 or 8 bytes of `opa` that a left shift by 8·`off` pushes past bit 63, moved down to bit 0. With `off` = 0 they return zero.
- R9: Code 0x30 clears byte lane i of `opa` (bits 8i+7..8i) for every i where `opb[i]` is 1.
- R10: Code 0x31 clears byte lane i of `opa` for every i where `opb[i]` is 0.
- R11: Code 0x39 shifts `opa` left, 0x34 shifts it right with zero fill, and 0x3c shifts it right with sign fill. The shift amount is `opb[5:0]`.
- R12: Any other function code gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A, the data operand |
| opb | input | 64 | Operand B: offset, lane mask or shift amount |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |

## Verification
The bench targets the zero-offset cases of the high forms. There, a design that fed the raw 64 − 0 shift through would return the whole operand from an insert-high, or clear bytes in a mask-high, instead of returning zero and A. Offset 7 with the 8-byte forms checks that spilled bytes are dropped or moved to the right lanes, not wrapped. A design that got this wrong would set bits in low lanes. Zap and zap-not get all-zero and all-one lane masks and walking patterns, which expose a swapped polarity or lane order. Random upper bits of B on byte operations catch an offset read from the wrong bits. An arithmetic shift of a negative operand by 63 catches zero fill used in place of sign fill.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_MSKL,
    CLS_MSKH,
    CLS_EXTL,
    CLS_EXTH,
    CLS_INSL,
    CLS_INSH,
    CLS_ZAP,
    CLS_ZAPNOT,
    CLS_SLL,
    CLS_SRL,
    CLS_SRA
  } bmu_cls_e;

  typedef struct packed {
    bmu_cls_e   cls;
    logic [1:0] size_log;  // field length is 2**size_log bytes
  } bmu_op_t;

  localparam int FUNC_W = 7;

  // operation codes; the issuing decoder depends on these values
  localparam logic [FUNC_W-1:0] OP_MSKL_B = 7'h02;
  localparam logic [FUNC_W-1:0] OP_MSKL_W = 7'h12;
  localparam logic [FUNC_W-1:0] OP_MSKL_L = 7'h22;
  localparam logic [FUNC_W-1:0] OP_MSKL_Q = 7'h32;
  localparam logic [FUNC_W-1:0] OP_MSKH_W = 7'h52;
  localparam logic [FUNC_W-1:0] OP_MSKH_L = 7'h62;
  localparam logic [FUNC_W-1:0] OP_MSKH_Q = 7'h72;
  localparam logic [FUNC_W-1:0] OP_EXTL_B = 7'h06;
  localparam logic [FUNC_W-1:0] OP_EXTL_W = 7'h16;
  localparam logic [FUNC_W-1:0] OP_EXTL_L = 7'h26;
  localparam logic [FUNC_W-1:0] OP_EXTL_Q = 7'h36;
  localparam logic [FUNC_W-1:0] OP_EXTH_W = 7'h5a;
  localparam logic [FUNC_W-1:0] OP_EXTH_L = 7'h6a;
  localparam logic [FUNC_W-1:0] OP_EXTH_Q = 7'h7a;
  localparam logic [FUNC_W-1:0] OP_INSL_B = 7'h0b;
  localparam logic [FUNC_W-1:0] OP_INSL_W = 7'h1b;
  localparam logic [FUNC_W-1:0] OP_INSL_L = 7'h2b;
  localparam logic [FUNC_W-1:0] OP_INSL_Q = 7'h3b;
  localparam logic [FUNC_W-1:0] OP_INSH_W = 7'h57;
  localparam logic [FUNC_W-1:0] OP_INSH_L = 7'h67;
  localparam logic [FUNC_W-1:0] OP_INSH_Q = 7'h77;
  localparam logic [FUNC_W-1:0] OP_ZAP    = 7'h30;
  localparam logic [FUNC_W-1:0] OP_ZAPNOT = 7'h31;
  localparam logic [FUNC_W-1:0] OP_SHL    = 7'h39;
  localparam logic [FUNC_W-1:0] OP_SHR    = 7'h34;
  localparam logic [FUNC_W-1:0] OP_SAR    = 7'h3c;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output bmu_op_t           op
);

  always_comb begin
    op.cls      = CLS_NONE;
    op.size_log = 2'd0;
    unique case (func)
      OP_MSKL_B: begin op.cls = CLS_MSKL; op.size_log = 2'd0; end
      OP_MSKL_W: begin op.cls = CLS_MSKL; op.size_log = 2'd1; end
      OP_MSKL_L: begin op.cls = CLS_MSKL; op.size_log = 2'd2; end
      OP_MSKL_Q: begin op.cls = CLS_MSKL; op.size_log = 2'd3; end
      OP_MSKH_W: begin op.cls = CLS_MSKH; op.size_log = 2'd1; end
      OP_MSKH_L: begin op.cls = CLS_MSKH; op.size_log = 2'd2; end
      OP_MSKH_Q: begin op.cls = CLS_MSKH; op.size_log = 2'd3; end
      OP_EXTL_B: begin op.cls = CLS_EXTL; op.size_log = 2'd0; end
      OP_EXTL_W: begin op.cls = CLS_EXTL; op.size_log = 2'd1; end
      OP_EXTL_L: begin op.cls = CLS_EXTL; op.size_log = 2'd2; end
      OP_EXTL_Q: begin op.cls = CLS_EXTL; op.size_log = 2'd3; end
      OP_EXTH_W: begin op.cls = CLS_EXTH; op.size_log = 2'd1; end
      OP_EXTH_L: begin op.cls = CLS_EXTH; op.size_log = 2'd2; end
      OP_EXTH_Q: begin op.cls = CLS_EXTH; op.size_log = 2'd3; end
      OP_INSL_B: begin op.cls = CLS_INSL; op.size_log = 2'd0; end
      OP_INSL_W: begin op.cls = CLS_INSL; op.size_log = 2'd1; end
      OP_INSL_L: begin op.cls = CLS_INSL; op.size_log = 2'd2; end
      OP_INSL_Q: begin op.cls = CLS_INSL; op.size_log = 2'd3; end
      OP_INSH_W: begin op.cls = CLS_INSH; op.size_log = 2'd1; end
      OP_INSH_L: begin op.cls = CLS_INSH; op.size_log = 2'd2; end
      OP_INSH_Q: begin op.cls = CLS_INSH; op.size_log = 2'd3; end
      OP_ZAP:    op.cls = CLS_ZAP;
      OP_ZAPNOT: op.cls = CLS_ZAPNOT;
      OP_SHL:    op.cls = CLS_SLL;
      OP_SHR:    op.cls = CLS_SRL;
      OP_SAR:    op.cls = CLS_SRA;
      default:   op.cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/bmu_lane_mask.sv
module bmu_lane_mask #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]       size_log,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] keep_lanes,  // lanes 0 .. len-1
  output logic [LANES-1:0] lo_lanes,    // field lanes inside the word
  output logic [LANES-1:0] hi_lanes     // field lanes spilled past the top
);

  int unsigned nbytes;
  logic [2*LANES-1:0] span;

  always_comb begin
    nbytes = 32'd1 << size_log;
    if (nbytes > LANES) nbytes = LANES;
    for (int i = 0; i < 2*LANES; i++) begin
      span[i] = (i >= int'(off)) && (i < int'(off) + int'(nbytes));
    end
    for (int i = 0; i < LANES; i++) begin
      keep_lanes[i] = (i < int'(nbytes));
    end
    lo_lanes = span[LANES-1:0];
    hi_lanes = span[2*LANES-1:LANES];
  end

endmodule

// File: rtl/bmu_lane_expand.sv
module bmu_lane_expand #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int W = LANES * BYTE_W
) (
  input  logic [LANES-1:0] lanes,
  output logic [W-1:0]     bits
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bits[g*BYTE_W +: BYTE_W] = {BYTE_W{lanes[g]}};
  end

endmodule

// File: rtl/bmu_shifter.sv
module bmu_shifter #(
  parameter int W = 64,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            shl,
  input  logic            arith,
  output logic [W-1:0]    dout
);

  logic [W-1:0] stage [0:SH_W];
  logic         fill;

  // left shifts run through the right-shift ladder on bit-reversed data
  assign fill = arith & ~shl & din[W-1];

  always_comb begin
    for (int i = 0; i < W; i++) begin
      stage[0][i] = shl ? din[W-1-i] : din[i];
    end
  end

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      dout[i] = shl ? stage[SH_W][W-1-i] : stage[SH_W][i];
    end
  end

endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFF_W  = $clog2(LANES),
  localparam int SH_W   = $clog2(DATA_W),
  localparam int BSH_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [6:0]        func,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  bmu_op_t          op;
  logic [OFF_W-1:0] off;
  logic [LANES-1:0] keep_lanes, lo_lanes, hi_lanes;
  logic [DATA_W-1:0] keep_bits, lo_bits, hi_bits, zap_bits;
  logic [SH_W-1:0]  byte_amt, wrap_amt, sh_amt;
  logic             sh_left, sh_arith;
  logic [DATA_W-1:0] sh_in, sh_out, nxt;

  assign off = opb[OFF_W-1:0];

  bmu_decode u_dec (.func(func), .op(op));

  bmu_lane_mask #(.LANES(LANES)) u_lanes (
    .size_log  (op.size_log),
    .off       (off),
    .keep_lanes(keep_lanes),
    .lo_lanes  (lo_lanes),
    .hi_lanes  (hi_lanes)
  );

  bmu_lane_expand #(.LANES(LANES), .BYTE_W(BYTE_W)) u_exp_keep (.lanes(keep_lanes), .bits(keep_bits));
  bmu_lane_expand #(.LANES(LANES), .BYTE_W(BYTE_W)) u_exp_lo   (.lanes(lo_lanes),   .bits(lo_bits));
  bmu_lane_expand #(.LANES(LANES), .BYTE_W(BYTE_W)) u_exp_hi   (.lanes(hi_lanes),   .bits(hi_bits));
  bmu_lane_expand #(.LANES(LANES), .BYTE_W(BYTE_W)) u_exp_zap  (.lanes(opb[LANES-1:0]), .bits(zap_bits));

  // byte offset in bits, and its complement modulo the word width
  assign byte_amt = SH_W'(off) << BSH_W;
  assign wrap_amt = SH_W'(0) - byte_amt;

  always_comb begin
    sh_in    = opa;
    sh_amt   = opb[SH_W-1:0];
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    unique case (op.cls)
      CLS_EXTL: sh_amt = byte_amt;
      CLS_EXTH: begin sh_amt = wrap_amt; sh_left = 1'b1; end
      CLS_INSL: begin sh_in = opa & keep_bits; sh_amt = byte_amt; sh_left = 1'b1; end
      CLS_INSH: begin sh_in = opa & keep_bits; sh_amt = wrap_amt; end
      CLS_SLL:  sh_left = 1'b1;
      CLS_SRA:  sh_arith = 1'b1;
      default:  ;
    endcase
  end

  bmu_shifter #(.W(DATA_W)) u_shift (
    .din  (sh_in),
    .amt  (sh_amt),
    .shl  (sh_left),
    .arith(sh_arith),
    .dout (sh_out)
  );

  always_comb begin
    unique case (op.cls)
      CLS_MSKL:   nxt = opa & ~lo_bits;
      CLS_MSKH:   nxt = opa & ~hi_bits;
      CLS_EXTL,
      CLS_EXTH:   nxt = sh_out & keep_bits;
      CLS_INSL:   nxt = sh_out;
      CLS_INSH:   nxt = (off == '0) ? '0 : sh_out;
      CLS_ZAP:    nxt = opa & ~zap_bits;
      CLS_ZAPNOT: nxt = opa & zap_bits;
      CLS_SLL,
      CLS_SRL,
      CLS_SRA:    nxt = sh_out;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R1: one-cycle latency on the strobe and result hold
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_result_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R3, R4, R9, R10: clearing operations never set a bit absent from A
  p_clear_subset_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op.cls inside {CLS_MSKL, CLS_MSKH, CLS_ZAP, CLS_ZAPNOT}))
    |=> ((result & ~$past(opa)) == '0));

  // R4: zero-offset high mask returns A
  p_mskh_zero_off_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op.cls == CLS_MSKH && opb[OFF_W-1:0] == '0)
    |=> (result == $past(opa)));

  // R5: single-byte extract is zero-extended
  p_extb_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == OP_EXTL_B) |=> (result[DATA_W-1:BYTE_W] == '0));

  // R8: zero-offset high insert returns zero
  p_insh_zero_off_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op.cls == CLS_INSH && opb[OFF_W-1:0] == '0) |=> (result == '0));

  // R12: unused codes give zero
  p_unused_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op.cls == CLS_NONE) |=> (result == '0));

endmodule

// File: tb/byte_lane_unit_test.sv
`timescale 1ns/1ps
module byte_lane_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  byte_lane_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  logic [6:0] codes [26] = '{7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
                             7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
                             7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77,
                             7'h30, 7'h31, 7'h39, 7'h34, 7'h3c};

  function automatic int field_bytes(logic [6:0] f);
    case (f[6:4])
      3'h0: return 1;
      3'h1, 3'h5: return 2;
      3'h2, 3'h6: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic string req_of(logic [6:0] f);
    case (f)
      7'h02, 7'h12, 7'h22, 7'h32: return "R3";
      7'h52, 7'h62, 7'h72:        return "R4";
      7'h06, 7'h16, 7'h26, 7'h36: return "R5";
      7'h5a, 7'h6a, 7'h7a:        return "R6";
      7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R7";
      7'h57, 7'h67, 7'h77:        return "R8";
      7'h30:                      return "R9";
      7'h31:                      return "R10";
      7'h39, 7'h34, 7'h3c:        return "R11";
      default:                    return "R12";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [6:0] f, logic [63:0] a, logic [63:0] b);
    int          ofs = int'(b[2:0]);
    int          nb = field_bytes(f);
    logic [63:0] keep = (nb == 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
    logic [127:0] fld = {64'd0, keep} << (8*ofs);
    logic [127:0] ins = {64'd0, a & keep} << (8*ofs);
    logic [63:0] zm = '0;
    for (int i = 0; i < 8; i++) if (b[i]) zm[8*i +: 8] = 8'hff;
    case (req_of(f))
      "R3":  return a & ~fld[63:0];
      "R4":  return a & ~fld[127:64];
      "R5":  return (a >> (8*ofs)) & keep;
      "R6":  return (a << ((64 - 8*ofs) % 64)) & keep;
      "R7":  return ins[63:0];
      "R8":  return ins[127:64];
      "R9":  return a & ~zm;
      "R10": return a & zm;
      "R11": begin
        if (f == 7'h39) return a << b[5:0];
        if (f == 7'h34) return a >> b[5:0];
        return 64'($signed(a) >>> b[5:0]);
      end
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(logic [6:0] f, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; func = f; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 strobe", {63'd0, out_valid}, 64'd1);
    check(req_of(f), result, model(f, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] hold, r2ref;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst = 1'b0;

    // directed corner cases
    run(7'h72, 64'h0123456789abcdef, 64'd0);          // R4 zero offset -> A
    run(7'h77, 64'hffffffffffffffff, 64'd0);          // R8 zero offset -> 0
    run(7'h77, 64'h0123456789abcdef, 64'd7);          // R8 offset 7
    run(7'h32, 64'h0123456789abcdef, 64'd7);          // R3 offset 7
    run(7'h3b, 64'h0123456789abcdef, 64'd7);          // R7 drop spill
    run(7'h7a, 64'h0123456789abcdef, 64'd0);          // R6 zero offset
    run(7'h5a, 64'h0123456789abcdef, 64'd3);          // R6
    run(7'h06, 64'h0123456789abcdef, 64'd5);          // R5
    run(7'h30, 64'h0123456789abcdef, 64'hff);         // R9 all lanes
    run(7'h30, 64'h0123456789abcdef, 64'h0);          // R9 none
    run(7'h31, 64'h0123456789abcdef, 64'h5a);         // R10
    run(7'h31, 64'h0123456789abcdef, 64'h0);          // R10 all cleared
    run(7'h3c, 64'h8000000000000000, 64'd63);         // R11 sign fill
    run(7'h34, 64'h8000000000000000, 64'd63);         // R11 zero fill
    run(7'h39, 64'h0000000000000001, 64'd63);         // R11
    run(7'h7f, 64'hffffffffffffffff, 64'hffffffffffffffff); // R12
    run(7'h00, 64'h0123456789abcdef, 64'd3);          // R12

    // R1: idle cycles hold the result and drop the strobe
    hold = result;
    @(negedge clk);
    check("R1 idle strobe", {63'd0, out_valid}, 64'd0);
    check("R1 idle hold", result, hold);

    // R2: upper B bits do not change byte operations
    run(7'h26, 64'hfedcba9876543210, 64'd2);
    r2ref = result;
    run(7'h26, 64'hfedcba9876543210, 64'hdeadbeef_0000fff2);
    check("R2 upper offset bits", result, r2ref);
    run(7'h67, 64'hfedcba9876543210, 64'hffffffff_fffffff5);

    // random
    for (int n = 0; n < 1500; n++) begin
      logic [6:0]  f;
      logic [63:0] a, b;
      if (($urandom % 16) == 0) f = 7'($urandom);
      else f = codes[$urandom % 26];
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run(f, a, b);
    end

    // R1: reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset again result", result, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule